// File: doc/BRIEF.md
# Selectable Line-Code Bit Encoder

This block turns a stream of serial data bits into a line-coded waveform for a transmitter output stage. Bits arrive over a valid/ready handshake. Each bit is spread over two half-periods, and an external half-period tick paces them. A two-bit mode input picks the line code: Manchester, Bi-Phase (mark), NRZ, or a direct mode in which a host-driven pin goes straight to the output. A polarity input inverts whatever the selected code produces.

A bit boundary is the tick that ends the second half of a bit. When no bit is in flight, every tick is a bit boundary. The block offers `bit_ready` only in the same cycle as a boundary tick, so the source may hold `bit_valid` high and the block takes one bit per boundary. The coded level is kept in a register and updates on the clock edge that carries the tick. When no bit is offered at a boundary, the encoder goes idle: its level returns to low, and the output then shows the polarity value.

Top module: `line_code_encoder`

## Requirements
- R1: The `mode` input encodes the line code as follows: 2'b00 is Manchester, 2'b01 is Bi-Phase, 2'b10 is NRZ and 2'b11 is direct drive.
- R2: In Manchester with `pol`=0, the first half of a bit equals the bit and the second half is its inverse. A 0 therefore rises at mid-bit and a 1 falls at mid-bit.
- R3: With `pol`=1, the output of every mode is the bitwise inverse of the output that `pol`=0 gives. This makes a Manchester 0 fall and a Manchester 1 rise at mid-bit.
- R4: In Manchester, when two consecutive bits are equal, the output also changes at the boundary between them.
- R5: In Bi-Phase, the level inverts at the start of every bit. For a 1 it inverts again at mid-bit, and for a 0 it holds through the bit. The first bit after idle starts from a low level.
- R6: In NRZ, the output holds the bit value, with polarity applied, for both halves of the bit.
- R7: In direct mode, `code_out` equals `direct_in` XOR `pol` within the same cycle, and `bit_ready` stays low.
- R8: `bit_ready` is high only in a cycle where `half_tick` marks a bit boundary (idle, or the end of a bit's second half) and the mode is not direct. A bit is taken when `bit_ready` and `bit_valid` are both high.
- R9: When no bit is taken at a boundary tick, the coded level becomes low from the next cycle on, so `code_out` equals `pol`.
- R10: After reset, the encoder is idle: with no tick, `bit_ready` is low and `code_out` equals `pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | One-cycle pulse marking the end of each half bit period |
| bit_valid | input | 1 | A data bit is offered |
| bit_data | input | 1 | The offered data bit |
| bit_ready | output | 1 | The offered bit is taken in this cycle |
| mode | input | 2 | Line-code select |
| pol | input | 1 | Output polarity invert |
| direct_in | input | 1 | Host-driven level for direct mode |
| code_out | output | 1 | Line-coded output |

## Verification
Some properties are checked on every cycle by the assertions. These are: a Manchester level flips at each mid-bit tick, an NRZ level holds across it, a Bi-Phase level flips at each bit start, the level returns to low after an idle boundary, and the handshake is stalled in direct mode and opens only on a tick. The bench sweeps every 4-bit pattern through each code at both polarities and predicts every half-period level arithmetically. Only those scenarios show the exact output values, the boundary edges between equal Manchester bits, and the direct pass-through.

// File: rtl/lcenc_pkg.sv
package lcenc_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        LM_MANCH   = 2'b00,
        LM_BIPHASE = 2'b01,
        LM_NRZ     = 2'b10,
        LM_DIRECT  = 2'b11
    } line_mode_e;

    typedef struct packed {
        logic busy;   // a bit is in flight
        logic phase;  // 0: first half, 1: second half
    } pace_state_t;

    // Level (before polarity) for the first half of a bit
    function automatic logic first_level(line_mode_e m, logic b, logic prev);
        case (m)
            LM_BIPHASE: return ~prev;
            default:    return b;
        endcase
    endfunction

    // Level (before polarity) for the second half of a bit
    function automatic logic second_level(line_mode_e m, logic b, logic first);
        case (m)
            LM_MANCH:   return ~b;
            LM_BIPHASE: return b ? ~first : first;
            default:    return first;
        endcase
    endfunction

endpackage

// File: rtl/lcenc_pacer.sv
module lcenc_pacer
    import lcenc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic half_tick,
    input  logic bit_valid,
    input  logic stall,
    output logic bit_ready,
    output logic accept,
    output logic mid_step,
    output logic idle_step
);
    pace_state_t st_q;
    logic        boundary_tick;

    assign boundary_tick = half_tick && (!st_q.busy || st_q.phase);
    assign bit_ready     = boundary_tick && !stall;
    assign accept        = bit_ready && bit_valid;
    assign mid_step      = half_tick && st_q.busy && !st_q.phase;
    assign idle_step     = boundary_tick && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (boundary_tick) begin
            st_q.busy  <= accept;
            st_q.phase <= 1'b0;
        end else if (mid_step) begin
            st_q.phase <= 1'b1;
        end
    end

    // R8
    ready_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        bit_ready |-> half_tick);

endmodule

// File: rtl/lcenc_shaper.sv
module lcenc_shaper
    import lcenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_mode_e mode,
    input  logic       accept,
    input  logic       bit_in,
    input  logic       mid_step,
    input  logic       idle_step,
    output logic       raw_level
);
    logic cur_bit_q;
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_bit_q <= 1'b0;
            level_q   <= 1'b0;
        end else if (accept) begin
            cur_bit_q <= bit_in;
            level_q   <= first_level(mode, bit_in, level_q);
        end else if (mid_step) begin
            level_q   <= second_level(mode, cur_bit_q, level_q);
        end else if (idle_step) begin
            level_q   <= 1'b0;
        end
    end

    assign raw_level = level_q;

endmodule

// File: rtl/line_code_encoder.sv
module line_code_encoder
    import lcenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              half_tick,
    input  logic              bit_valid,
    input  logic              bit_data,
    output logic              bit_ready,
    input  logic [MODE_W-1:0] mode,
    input  logic              pol,
    input  logic              direct_in,
    output logic              code_out
);
    line_mode_e mode_e;
    logic       is_direct;
    logic       accept;
    logic       mid_step;
    logic       idle_step;
    logic       raw_level;

    assign mode_e    = line_mode_e'(mode);
    assign is_direct = (mode_e == LM_DIRECT);

    lcenc_pacer u_pacer (
        .clk       (clk),
        .rst       (rst),
        .half_tick (half_tick),
        .bit_valid (bit_valid),
        .stall     (is_direct),
        .bit_ready (bit_ready),
        .accept    (accept),
        .mid_step  (mid_step),
        .idle_step (idle_step)
    );

    lcenc_shaper u_shaper (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .accept    (accept),
        .bit_in    (bit_data),
        .mid_step  (mid_step),
        .idle_step (idle_step),
        .raw_level (raw_level)
    );

    assign code_out = (is_direct ? direct_in : raw_level) ^ pol;

    // R2
    manch_mid_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (mid_step && mode_e == LM_MANCH) |=> (raw_level != $past(raw_level)));

    // R6
    nrz_mid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mid_step && mode_e == LM_NRZ) |=> $stable(raw_level));

    // R5
    biphase_start_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && mode_e == LM_BIPHASE) |=> (raw_level != $past(raw_level)));

    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        idle_step |=> !raw_level);

    // R7
    direct_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_e == LM_DIRECT) |-> !bit_ready);

endmodule

// File: tb/tb_line_code_encoder.sv
`timescale 1ns/1ps
module tb_line_code_encoder;
    import lcenc_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic       half_tick;
    logic       bit_valid;
    logic       bit_data;
    logic       bit_ready;
    logic [1:0] mode;
    logic       pol;
    logic       direct_in;
    logic       code_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    line_code_encoder dut (
        .clk(clk), .rst(rst), .half_tick(half_tick), .bit_valid(bit_valid),
        .bit_data(bit_data), .bit_ready(bit_ready), .mode(mode), .pol(pol),
        .direct_in(direct_in), .code_out(code_out)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Sends n bits of pat (LSB first) in mode m, then one idle boundary
    task automatic run_pattern(input logic [1:0] m, input logic p,
                               input int n, input logic [3:0] pat);
        logic  lvl;
        logic  first;
        logic  second;
        logic  prev_b;
        logic  prev_out;
        string tag;
        lvl = 1'b0;
        prev_b = 1'b0;
        prev_out = 1'b0;
        tag = p ? "R3" : (m == 2'b00 ? "R2" : (m == 2'b01 ? "R5" : "R6"));
        mode = m;
        pol  = p;
        for (int i = 0; i < n; i++) begin
            logic b;
            b = pat[i];
            // expected levels from the requirements, before polarity
            case (m)
                2'b00: begin first = b; second = ~b; end
                2'b01: begin first = ~lvl; second = b ? lvl : ~lvl; end
                default: begin first = b; second = b; end
            endcase
            lvl = second;
            @(negedge clk);
            bit_valid = 1'b1; bit_data = b; half_tick = 1'b1;
            #1 chk(bit_ready, 1'b1, "R8 ready at boundary");
            @(negedge clk);
            half_tick = 1'b0; bit_valid = 1'b0;
            #1 chk(code_out, first ^ p, tag);
            if (m == 2'b00 && i > 0 && b == prev_b)
                chk(code_out != prev_out, 1'b1, "R4 boundary edge");
            repeat (2) @(negedge clk);
            half_tick = 1'b1; bit_valid = 1'b1;
            #1 chk(bit_ready, 1'b0, "R8 no ready mid-bit");
            @(negedge clk);
            half_tick = 1'b0; bit_valid = 1'b0;
            #1 chk(code_out, second ^ p, tag);
            prev_out = code_out;
            prev_b = b;
            repeat (2) @(negedge clk);
        end
        @(negedge clk);
        half_tick = 1'b1;
        #1 chk(bit_ready, 1'b1, "R8 ready at boundary");
        @(negedge clk);
        half_tick = 1'b0;
        #1 chk(code_out, p, "R9 idle after stream");
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; half_tick = 1'b0; bit_valid = 1'b0; bit_data = 1'b0;
        mode = 2'b00; pol = 1'b0; direct_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R10
        chk(bit_ready, 1'b0, "R10 reset ready");
        chk(code_out, 1'b0, "R10 reset output");
        pol = 1'b1;
        #1 chk(code_out, 1'b1, "R10 reset output with pol");

        // R1 sweep: modes 00, 01, 10 with both polarities, all 4-bit patterns
        for (int m = 0; m < 3; m++)
            for (int p = 0; p < 2; p++)
                for (int pat = 0; pat < 16; pat++)
                    run_pattern(m[1:0], p[0], 4, pat[3:0]);

        // R7 direct drive
        for (int p = 0; p < 2; p++) begin
            @(negedge clk);
            mode = 2'b11; pol = p[0];
            for (int v = 0; v < 2; v++) begin
                direct_in = v[0];
                #1 chk(code_out, v[0] ^ p[0], "R7 direct follow");
            end
            bit_valid = 1'b1; bit_data = 1'b1; half_tick = 1'b1; direct_in = 1'b0;
            #1 chk(bit_ready, 1'b0, "R7 stalled handshake");
            @(negedge clk);
            half_tick = 1'b0; bit_valid = 1'b0;
            #1 chk(code_out, p[0], "R7 direct after tick");
            // back to NRZ: no bit was taken, level is idle
            mode = 2'b10;
            #1 chk(code_out, p[0], "R9 no bit taken in direct");
            repeat (2) @(negedge clk);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule